// File: doc/BRIEF.md
# Boot Vector Address Remap Decoder

This block is the address decoder between a small processor's bus master port and two memory slaves, a ROM and a RAM, using AHB-Lite-style address and data phases. At reset a remap flag is armed. While it is armed, the two 32-bit words at the very bottom of the map hold the initial stack pointer and the reset handler. An access to either word is steered to the first two words of RAM. The processor therefore boots from a vector pair that firmware placed in RAM, and the core itself is not changed.

The address phase is purely combinational: the decoder picks the target and rewrites the address in the same cycle. The chosen target is registered at the end of the address phase. In the following data phase it steers read data, ready and response back to the master, so no wait state is added. Software clears the remap by writing a 1 to bit 0 of a control word at byte address 0x0000_2000. Once cleared, the remap stays off until the next reset. Writes into ROM, and accesses to unmapped addresses, are answered by an internal default slave with a two-cycle error.

The default slave is a three-state machine:
- `DS_IDLE` returns ready with an OKAY response.
- `DS_ERR_WAIT` is the first error cycle: ready low, response ERROR.
- `DS_ERR_LAST` is the second error cycle: ready high, response ERROR.

Its transitions are:
- `DS_IDLE` moves to `DS_ERR_WAIT` when an error transfer is accepted.
- `DS_ERR_WAIT` moves to `DS_ERR_LAST` unconditionally.
- `DS_ERR_LAST` moves to `DS_ERR_WAIT` if another error transfer is accepted, and otherwise to `DS_IDLE`.

The data-phase target register holds one of these values: `TGT_NONE`, `TGT_ROM`, `TGT_RAM`, `TGT_CTRL` or `TGT_ERR`.

Top module: `boot_remap_fabric`

## Requirements
- R1: With remap cleared, an access to byte addresses 0x0000_0000 to 0x0000_0FFF selects the ROM with the address unchanged, including addresses 0x0 and 0x4. At most one of the ROM and RAM selects is high at any time.
- R2: An access to byte addresses 0x0000_1000 to 0x0000_1FFF selects the RAM with the address unchanged.
- R3: While remap is set, an access to byte addresses 0x0 to 0x7, read or write, selects the RAM at address 0x0000_1000 plus the low three address bits. Address 0x0 thus reaches RAM word 0x1000, and address 0x4 reaches RAM word 0x1004.
- R4: Remap is set by reset and is already in effect for the first transfer issued after reset is released.
- R5: While remap is set, ROM addresses from 0x8 upward still select the ROM with the address unchanged.
- R6: A transfer to ROM, RAM or the control word completes with the slave's ready and read data in the first data-phase cycle. Back-to-back transfers proceed with no inserted wait cycle.
- R7: The control word at byte address 0x0000_2000 reads as remap in bit 0 and zeros in bits 31 to 1. A write with bit 0 set clears the remap. A write with bit 0 clear has no effect.
- R8: Once cleared, remap cannot be set again by any write. Only a reset sets it again.
- R9: A write to the ROM region that is not a remapped vector write is answered with the two-cycle error of R10.
- R10: Any address at or above 0x0000_2000 other than the control word produces an error. The first data-phase cycle has ready low and response high. The second cycle has ready high and response high.
- R11: During reset, and in the data phase following an idle transfer (trans code 00 or 01), the master sees ready high and an OKAY response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset; arms the remap |
| m_haddr | input | 32 | Master byte address (address phase) |
| m_htrans | input | 2 | Master transfer type; 10 or 11 means a valid transfer |
| m_hwrite | input | 1 | Master write strobe (address phase) |
| m_hwdata | input | 32 | Master write data (data phase) |
| m_hrdata | output | 32 | Read data returned to the master |
| m_hready | output | 1 | Transfer done; also fed to the slaves as the bus ready |
| m_hresp | output | 1 | 1 means an error response |
| s_haddr | output | 32 | Rewritten address shared by both memories |
| s_hwdata | output | 32 | Write data forwarded to the memories |
| rom_hsel | output | 1 | ROM select (address phase) |
| ram_hsel | output | 1 | RAM select (address phase) |
| rom_hrdata | input | 32 | ROM read data |
| rom_hreadyout | input | 1 | ROM ready |
| rom_hresp | input | 1 | ROM response |
| ram_hrdata | input | 32 | RAM read data |
| ram_hreadyout | input | 1 | RAM ready |
| ram_hresp | input | 1 | RAM response |

## Verification
The bench aims first at the first fetch after reset release. A decoder whose remap flag came up cleared, or one cycle late, would return the ROM's stack pointer there. It also covers the byte-offset vector address 0x6 and the neighbouring word 0x8. A rewrite that is too wide would steal 0x8 from ROM, and one that is too narrow would leave 0x6 in ROM. The control word is exercised with a write of 0 that must not clear the remap, with a clearing write, and with a later write that must not set it again. A reset follows, which must re-arm the remap. Finally, error transfers, idle cycles and pipelined reads expose three faults: a missing or single-cycle error, a response stuck from a previous transfer, and a data phase that inserts a wait.

// File: rtl/boot_remap_pkg.sv
`timescale 1ns/1ps
package boot_remap_pkg;
    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_ROM,
        TGT_RAM,
        TGT_CTRL,
        TGT_ERR
    } tgt_e;

    typedef enum logic [1:0] {
        DS_IDLE,
        DS_ERR_WAIT,
        DS_ERR_LAST
    } ds_state_e;
endpackage

// File: rtl/remap_addr_decode.sv
`timescale 1ns/1ps
module remap_addr_decode
    import boot_remap_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int REGION_BITS = 12,
    parameter int VEC_BITS    = 3
) (
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hwrite,
    input  logic              remap_on,
    output tgt_e              tgt,
    output logic [ADDR_W-1:0] slv_haddr
);
    localparam int REG_W = ADDR_W - REGION_BITS;
    localparam logic [REG_W-1:0]  ROM_REG   = '0;
    localparam logic [REG_W-1:0]  RAM_REG   = REG_W'(1);
    localparam logic [ADDR_W-1:0] RAM_BASE  = ADDR_W'(1) << REGION_BITS;
    localparam logic [ADDR_W-1:0] CTRL_BASE = ADDR_W'(2) << REGION_BITS;

    logic [REG_W-1:0] region;
    logic             is_vec;

    assign region = haddr[ADDR_W-1:REGION_BITS];
    assign is_vec = remap_on && (haddr[ADDR_W-1:VEC_BITS] == '0);

    always_comb begin
        slv_haddr = haddr;
        tgt       = TGT_ERR;
        if (is_vec) begin
            tgt       = TGT_RAM;
            slv_haddr = RAM_BASE | {{(ADDR_W-VEC_BITS){1'b0}}, haddr[VEC_BITS-1:0]};
        end else if (region == ROM_REG) begin
            tgt = hwrite ? TGT_ERR : TGT_ROM;
        end else if (region == RAM_REG) begin
            tgt = TGT_RAM;
        end else if (haddr[ADDR_W-1:2] == CTRL_BASE[ADDR_W-1:2]) begin
            tgt = TGT_CTRL;
        end
    end
endmodule

// File: rtl/remap_flag.sv
`timescale 1ns/1ps
module remap_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_req,
    output logic remap_on
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       remap_on <= 1'b1;
        else if (clr_req) remap_on <= 1'b0;
    end

    // R8: once cleared, nothing but reset sets it again
    p_sticky_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !remap_on |=> !remap_on)
        else $error("remap flag set again without reset");
endmodule

// File: rtl/remap_default_slave.sv
`timescale 1ns/1ps
module remap_default_slave
    import boot_remap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic readyout,
    output logic resp
);
    ds_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_IDLE:     if (start) state_d = DS_ERR_WAIT;
            DS_ERR_WAIT: state_d = DS_ERR_LAST;
            DS_ERR_LAST: state_d = start ? DS_ERR_WAIT : DS_IDLE;
            default:     state_d = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            DS_IDLE:     begin readyout = 1'b1; resp = 1'b0; end
            DS_ERR_WAIT: begin readyout = 1'b0; resp = 1'b1; end
            DS_ERR_LAST: begin readyout = 1'b1; resp = 1'b1; end
            default:     begin readyout = 1'b1; resp = 1'b0; end
        endcase
    end

    // R10: the error always spans two cycles
    p_err_two_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DS_ERR_WAIT) |=> (state_q == DS_ERR_LAST))
        else $error("error response not two cycles");
endmodule

// File: rtl/remap_dphase_mux.sv
`timescale 1ns/1ps
module remap_dphase_mux
    import boot_remap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  tgt_e              addr_tgt,
    input  logic              hwrite,
    input  logic              wdata_b0,
    input  logic              remap_on,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic              rom_ready,
    input  logic              rom_resp,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              ram_ready,
    input  logic              ram_resp,
    input  logic              ds_ready,
    input  logic              ds_resp,
    output logic [DATA_W-1:0] hrdata,
    output logic              hready,
    output logic              hresp,
    output logic              ctrl_clr
);
    tgt_e dp_tgt;
    logic dp_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_tgt   <= TGT_NONE;
            dp_write <= 1'b0;
        end else if (hready) begin
            dp_tgt   <= accept ? addr_tgt : TGT_NONE;
            dp_write <= accept && hwrite;
        end
    end

    always_comb begin
        hrdata = '0;
        hready = 1'b1;
        hresp  = 1'b0;
        unique case (dp_tgt)
            TGT_NONE: ;
            TGT_ROM:  begin hrdata = rom_rdata; hready = rom_ready; hresp = rom_resp; end
            TGT_RAM:  begin hrdata = ram_rdata; hready = ram_ready; hresp = ram_resp; end
            TGT_CTRL: hrdata = {{(DATA_W-1){1'b0}}, remap_on};
            TGT_ERR:  begin hready = ds_ready; hresp = ds_resp; end
            default:  ;
        endcase
    end

    assign ctrl_clr = (dp_tgt == TGT_CTRL) && dp_write && wdata_b0;

    // R11: an idle transfer gets a ready OKAY data phase
    p_idle_okay_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && !accept) |=> (hready && !hresp))
        else $error("idle data phase not OKAY");
endmodule

// File: rtl/boot_remap_fabric.sv
`timescale 1ns/1ps
module boot_remap_fabric
    import boot_remap_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int REGION_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] m_haddr,
    input  logic [1:0]        m_htrans,
    input  logic              m_hwrite,
    input  logic [DATA_W-1:0] m_hwdata,
    output logic [DATA_W-1:0] m_hrdata,
    output logic              m_hready,
    output logic              m_hresp,
    output logic [ADDR_W-1:0] s_haddr,
    output logic [DATA_W-1:0] s_hwdata,
    output logic              rom_hsel,
    output logic              ram_hsel,
    input  logic [DATA_W-1:0] rom_hrdata,
    input  logic              rom_hreadyout,
    input  logic              rom_hresp,
    input  logic [DATA_W-1:0] ram_hrdata,
    input  logic              ram_hreadyout,
    input  logic              ram_hresp
);
    tgt_e tgt;
    logic remap_on, valid, ctrl_clr, ds_ready, ds_resp;

    assign valid    = m_htrans inside {2'b10, 2'b11};
    assign s_hwdata = m_hwdata;

    remap_addr_decode #(.ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS), .VEC_BITS(3)) u_dec (
        .haddr(m_haddr), .hwrite(m_hwrite), .remap_on(remap_on),
        .tgt(tgt), .slv_haddr(s_haddr)
    );

    assign rom_hsel = (tgt == TGT_ROM);
    assign ram_hsel = (tgt == TGT_RAM);

    remap_flag u_flag (
        .clk(clk), .rst_n(rst_n), .clr_req(ctrl_clr), .remap_on(remap_on)
    );

    remap_default_slave u_ds (
        .clk(clk), .rst_n(rst_n),
        .start(valid && m_hready && (tgt == TGT_ERR)),
        .readyout(ds_ready), .resp(ds_resp)
    );

    remap_dphase_mux #(.DATA_W(DATA_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .accept(valid), .addr_tgt(tgt),
        .hwrite(m_hwrite), .wdata_b0(m_hwdata[0]), .remap_on(remap_on),
        .rom_rdata(rom_hrdata), .rom_ready(rom_hreadyout), .rom_resp(rom_hresp),
        .ram_rdata(ram_hrdata), .ram_ready(ram_hreadyout), .ram_resp(ram_hresp),
        .ds_ready(ds_ready), .ds_resp(ds_resp),
        .hrdata(m_hrdata), .hready(m_hready), .hresp(m_hresp), .ctrl_clr(ctrl_clr)
    );

    // R1: never both memories selected
    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_hsel, ram_hsel}))
        else $error("both memories selected");

    // R3: vector words land in RAM while remap is set
    p_vec_to_ram_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (remap_on && valid && (m_haddr[ADDR_W-1:3] == '0)) |-> (ram_hsel && !rom_hsel))
        else $error("vector access not steered to RAM");

    // R9: a write never selects the ROM
    p_no_rom_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && m_hwrite) |-> !rom_hsel)
        else $error("write reached ROM");
endmodule

// File: tb/boot_remap_fabric_test.sv
`timescale 1ns/1ps
module boot_remap_fabric_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] m_haddr = '0;
    logic [1:0]  m_htrans = 2'b00;
    logic        m_hwrite = 1'b0;
    logic [31:0] m_hwdata = '0;
    logic [31:0] m_hrdata, s_haddr, s_hwdata, rom_hrdata, ram_hrdata;
    logic        m_hready, m_hresp, rom_hsel, ram_hsel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    boot_remap_fabric uut (
        .clk(clk), .rst_n(rst_n), .m_haddr(m_haddr), .m_htrans(m_htrans),
        .m_hwrite(m_hwrite), .m_hwdata(m_hwdata), .m_hrdata(m_hrdata),
        .m_hready(m_hready), .m_hresp(m_hresp), .s_haddr(s_haddr), .s_hwdata(s_hwdata),
        .rom_hsel(rom_hsel), .ram_hsel(ram_hsel),
        .rom_hrdata(rom_hrdata), .rom_hreadyout(1'b1), .rom_hresp(1'b0),
        .ram_hrdata(ram_hrdata), .ram_hreadyout(1'b1), .ram_hresp(1'b0)
    );

    // Memory slaves: zero-wait synchronous arrays
    logic [31:0] ram_mem [1024];
    logic [9:0]  rom_idx = '0, ram_idx = '0;
    logic        ram_dp = 1'b0, ram_wr = 1'b0;

    assign rom_hrdata = 32'hA000_0000 | {22'd0, rom_idx};
    assign ram_hrdata = ram_mem[ram_idx];

    always @(posedge clk) begin
        if (ram_dp && ram_wr && m_hready) ram_mem[ram_idx] <= s_hwdata;
        if (m_hready) begin
            if (rom_hsel && m_htrans[1]) rom_idx <= s_haddr[11:2];
            ram_dp <= ram_hsel && m_htrans[1];
            ram_wr <= m_hwrite;
            if (ram_hsel && m_htrans[1]) ram_idx <= s_haddr[11:2];
        end
    end

    // Reference model state
    logic [31:0] ref_ram [1024];
    bit remap_m = 1'b1;

    localparam int K_ROM = 0, K_RAM = 1, K_CTRL = 2, K_ERR = 3;

    task automatic model(input logic [31:0] a, input logic wr, output int kind, output int idx);
        idx = int'(a[11:2]);
        if (remap_m && a < 32'h8) begin kind = K_RAM; idx = int'(a[2]); end
        else if (a < 32'h1000) kind = wr ? K_ERR : K_ROM;
        else if (a < 32'h2000) kind = K_RAM;
        else if (a[31:2] == 30'h800) kind = K_CTRL;
        else kind = K_ERR;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] a, input logic wr, input logic [31:0] wd, input string tag);
        int kind, idx;
        logic [31:0] expd;
        model(a, wr, kind, idx);
        @(negedge clk);
        m_haddr = a; m_htrans = 2'b10; m_hwrite = wr;
        @(negedge clk);
        m_htrans = 2'b00; m_hwdata = wd;
        #1;
        if (kind == K_ERR) begin
            chk({tag, " err first {ready,resp}"}, {30'd0, m_hready, m_hresp}, 32'd1);
            @(negedge clk); #1;
            chk({tag, " err second {ready,resp}"}, {30'd0, m_hready, m_hresp}, 32'd3);
        end else begin
            chk({tag, " zero-wait {ready,resp}"}, {30'd0, m_hready, m_hresp}, 32'd2);
            if (!wr) begin
                case (kind)
                    K_ROM:   expd = 32'hA000_0000 | idx;
                    K_RAM:   expd = ref_ram[idx];
                    default: expd = {31'd0, remap_m};
                endcase
                chk({tag, " rdata"}, m_hrdata, expd);
            end else if (kind == K_RAM) begin
                ref_ram[idx] = wd;
            end else if (kind == K_CTRL && wd[0]) begin
                remap_m = 1'b0;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; m_htrans = 2'b00;
        #1;
        chk("R11 reset ready", {31'd0, m_hready}, 32'd1);
        chk("R11 reset resp", {31'd0, m_hresp}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        remap_m = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            ram_mem[i] = 32'hB000_0000 | i;
            ref_ram[i] = 32'hB000_0000 | i;
        end
        repeat (2) @(negedge clk);
        do_reset();
        xfer(32'h0, 0, 0, "R4 first fetch stack pointer");
        xfer(32'h4, 0, 0, "R3 reset handler read");
        xfer(32'h6, 0, 0, "R3 byte offset in vector");
        xfer(32'h8, 0, 0, "R5 word after vectors");
        xfer(32'hFFC, 0, 0, "R5 top of ROM");
        xfer(32'h4, 1, 32'h0000_1235, "R3 vector write");
        xfer(32'h1004, 0, 0, "R2 RAM sees vector write");
        xfer(32'h1FFC, 0, 0, "R2 top of RAM");
        xfer(32'h8, 1, 32'hDEAD, "R9 ROM write");
        xfer(32'h3000, 0, 0, "R10 unmapped read");
        xfer(32'h2004, 1, 1, "R10 beside control word");
        xfer(32'h2000, 0, 0, "R7 control reads armed");
        xfer(32'h2000, 1, 32'hFFFF_FFFE, "R7 write bit0 clear");
        xfer(32'h2000, 0, 0, "R7 no effect of bit0 clear");
        xfer(32'h2000, 1, 32'h1, "R7 clear write");
        xfer(32'h2000, 0, 0, "R7 reads cleared");
        xfer(32'h0, 0, 0, "R1 addr 0 to ROM after clear");
        xfer(32'h4, 0, 0, "R1 addr 4 to ROM after clear");
        xfer(32'h0, 1, 32'h55, "R9 vector write after clear");
        xfer(32'h2000, 1, 32'h1, "R8 rewrite");
        xfer(32'h2000, 0, 0, "R8 stays cleared");
        // R11: idle transfer to an unmapped address
        @(negedge clk); m_haddr = 32'h3000; m_htrans = 2'b01;
        @(negedge clk); m_htrans = 2'b00; #1;
        chk("R11 idle {ready,resp}", {30'd0, m_hready, m_hresp}, 32'd2);
        // R6: back-to-back reads
        @(negedge clk); m_haddr = 32'h1008; m_htrans = 2'b10; m_hwrite = 1'b0;
        @(negedge clk); m_haddr = 32'h10; m_htrans = 2'b10; #1;
        chk("R6 first pipelined ready", {31'd0, m_hready}, 32'd1);
        chk("R6 first pipelined rdata", m_hrdata, ref_ram[2]);
        @(negedge clk); m_htrans = 2'b00; #1;
        chk("R6 second pipelined ready", {31'd0, m_hready}, 32'd1);
        chk("R6 second pipelined rdata", m_hrdata, 32'hA000_0004);
        // R8: reset re-arms
        do_reset();
        xfer(32'h2000, 0, 0, "R8 re-armed by reset");
        xfer(32'h4, 0, 0, "R4 vector after second reset");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule